// File: doc/BRIEF.md
# Masked Set/Clear GPIO Port

This block is one 32-bit general purpose I/O port behind a simple single-cycle register bus. It holds a per-bit direction, an output latch and a protection mask, drives `pad_out` and `pad_oe` toward the pads, and brings pad levels back in through a two-stage synchronizer. Two register views act on the same direction and output state. The legacy view has a direction register and separate write-one-to-set and write-one-to-clear registers. The fast view adds a protection mask, a whole-port value register and per-byte write enables.

Software uses the set and clear registers to change individual bits without a read-modify-write sequence. It uses the fast view to update a group of bits in one access while the masked bits keep their value. Reads come back one cycle after the request, with `bus_rvalid` high.

Top module: `mgpio_port`

## Requirements
- R1: After a synchronous active-low reset, direction, output latch and mask are all zero, so `pad_oe` and `pad_out` are zero.
- R2: `pad_oe` bit n equals direction bit n (1 means output). Direction is written at word index 0 (legacy, all 32 bits) or at index 8 (fast, per byte lane). Both indexes read back the direction.
- R3: A write to index 1 (legacy set) sets every output bit whose data bit is 1. Bits written as 0 keep their value. The mask has no effect here.
- R4: A write to index 2 (legacy clear) clears every output bit whose data bit is 1. Bits written as 0 keep their value. The mask has no effect here.
- R5: A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. Indexes 1, 2, 11 and 12 return the output latch. Index 3 returns the synchronized pin state.
- R6: A change on `pad_in` is seen by a read only when the read request is issued at least two clock edges after the change (two flops in the synchronizer).
- R7: The mask is at index 9 and resets to zero. A mask bit of 1 keeps its output bit unchanged during fast value (10), fast set (11) and fast clear (12) writes.
- R8: A write to index 10 loads every unmasked bit in an enabled byte lane from the write data in one access.
- R9: On fast-view writes (indexes 8 to 12), `bus_be[k]` enables bits 8k+7 down to 8k. Bits in a disabled lane keep their value. Legacy writes ignore `bus_be`.
- R10: A read of index 10 returns the synchronized pin state with 0 in every masked bit.
- R11: A read of an unmapped index returns 0. A write to an unmapped index changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register word index |
| bus_be | input | 4 | Byte-lane write enables (fast view) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output latch toward the pads |
| pad_oe | output | 32 | Per-pad output enable |

## Verification
The assertions take for granted that each cycle brings at most one bus access, and that `bus_sel` and `bus_we` are at defined levels from the first clock edge. Under those conditions every change of the output latch can be traced to exactly one write in the previous cycle. The bench drives every access as a single-cycle pulse between falling edges and keeps the bus idle at all other times. It changes `pad_in` only at falling edges, so the synchronizer and read timing can be predicted to the cycle.

// File: rtl/mgpio_pkg.sv
// Package mgpio_pkg
// Shared register indexes and the write-strobe bundle for the GPIO port.
// Assumes a word-indexed register bus, 5 index bits wide.
package mgpio_pkg;

    typedef enum logic [4:0] {
        IDX_DIR   = 5'd0,
        IDX_SET   = 5'd1,
        IDX_CLR   = 5'd2,
        IDX_PIN   = 5'd3,
        IDX_FDIR  = 5'd8,
        IDX_FMASK = 5'd9,
        IDX_FVAL  = 5'd10,
        IDX_FSET  = 5'd11,
        IDX_FCLR  = 5'd12
    } reg_idx_e;

    typedef struct packed {
        logic dir_l;
        logic set_l;
        logic clr_l;
        logic dir_f;
        logic mask_f;
        logic val_f;
        logic set_f;
        logic clr_f;
    } wr_strobe_t;

endpackage

// File: rtl/mgpio_sync.sv
// Module mgpio_sync
// Brings asynchronous pad levels into the clock domain through a chain
// of STAGES flops per bit. Assumes STAGES >= 2.
module mgpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // first stage samples the pads
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // each later stage copies the one before it
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/mgpio_decode.sv
// Module mgpio_decode
// Turns one bus write into per-register strobes and expands the byte
// enables into a per-bit lane vector. Assumes WIDTH is a multiple of 8.
module mgpio_decode
    import mgpio_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int LANES = WIDTH / 8
) (
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [4:0]       bus_addr,
    input  logic [LANES-1:0] bus_be,
    output wr_strobe_t       stb,
    output logic [WIDTH-1:0] lane_bits
);

    logic wr;
    assign wr = bus_sel & bus_we;

    // one strobe per writable register
    always_comb begin
        stb        = '0;
        stb.dir_l  = wr && (bus_addr == IDX_DIR);
        stb.set_l  = wr && (bus_addr == IDX_SET);
        stb.clr_l  = wr && (bus_addr == IDX_CLR);
        stb.dir_f  = wr && (bus_addr == IDX_FDIR);
        stb.mask_f = wr && (bus_addr == IDX_FMASK);
        stb.val_f  = wr && (bus_addr == IDX_FVAL);
        stb.set_f  = wr && (bus_addr == IDX_FSET);
        stb.clr_f  = wr && (bus_addr == IDX_FCLR);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_bits[8*k +: 8] = {8{bus_be[k]}};
    end

endmodule

// File: rtl/mgpio_state.sv
// Module mgpio_state
// Holds direction, output latch and protection mask. Legacy writes use
// all bits and ignore the mask. Fast writes use byte lanes, and the mask
// guards the output latch. Assumes at most one strobe per cycle.
module mgpio_state
    import mgpio_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_strobe_t       stb,
    input  logic [WIDTH-1:0] lane_bits,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] mask_q
);

    logic [WIDTH-1:0] dir_n, out_n, mask_n, fast_en;

    assign fast_en = lane_bits & ~mask_q;

    // next direction from either view
    always_comb begin
        dir_n = dir_q;
        if (stb.dir_l) dir_n = wdata;
        if (stb.dir_f) dir_n = (dir_q & ~lane_bits) | (wdata & lane_bits);
    end

    // next mask, per lane
    always_comb begin
        mask_n = mask_q;
        if (stb.mask_f) mask_n = (mask_q & ~lane_bits) | (wdata & lane_bits);
    end

    // next output latch; a clear is applied after a set
    always_comb begin
        out_n = out_q;
        if (stb.set_l) out_n = out_n | wdata;
        if (stb.val_f) out_n = (out_n & ~fast_en) | (wdata & fast_en);
        if (stb.set_f) out_n = out_n | (wdata & fast_en);
        if (stb.clr_l) out_n = out_n & ~wdata;
        if (stb.clr_f) out_n = out_n & ~(wdata & fast_en);
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            mask_q <= '0;
        end else begin
            dir_q  <= dir_n;
            out_q  <= out_n;
            mask_q <= mask_n;
        end
    end

endmodule

// File: rtl/mgpio_port.sv
// Module mgpio_port
// A GPIO port with a legacy set/clear view and a masked fast view over
// one shared state. Reads are registered: data appears with bus_rvalid
// one cycle after the request. Assumes one bus access per cycle.
module mgpio_port
    import mgpio_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SYNC_STAGES = 2,
    localparam int LANES = WIDTH / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [4:0]       bus_addr,
    input  logic [LANES-1:0] bus_be,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             bus_rvalid,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    wr_strobe_t       stb;
    logic [WIDTH-1:0] lane_bits;
    logic [WIDTH-1:0] dir_q, out_q, mask_q, pin_s;
    logic [WIDTH-1:0] rd_mux;

    mgpio_decode #(.WIDTH(WIDTH)) u_decode (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .stb       (stb),
        .lane_bits (lane_bits)
    );

    mgpio_state #(.WIDTH(WIDTH)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb),
        .lane_bits (lane_bits),
        .wdata     (bus_wdata),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .mask_q    (mask_q)
    );

    mgpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_s)
    );

    // read data selection by register index
    always_comb begin
        case (bus_addr)
            IDX_DIR, IDX_FDIR:                    rd_mux = dir_q;
            IDX_SET, IDX_CLR, IDX_FSET, IDX_FCLR: rd_mux = out_q;
            IDX_PIN:                              rd_mux = pin_s;
            IDX_FMASK:                            rd_mux = mask_q;
            IDX_FVAL:                             rd_mux = pin_s & ~mask_q;
            default:                              rd_mux = '0;
        endcase
    end

    // registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_sel & ~bus_we;
            if (bus_sel && !bus_we) bus_rdata <= rd_mux;
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

endmodule

// File: rtl/mgpio_port_chk.sv
// Module mgpio_port_chk
// Checks the port behaviour over time. It is attached to mgpio_port by
// the bind below. Assumes at most one bus access per cycle.
module mgpio_port_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [4:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic             bus_rvalid,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] mask_q
);

    logic wr;
    logic fast_out_wr;
    assign wr          = bus_sel && bus_we;
    assign fast_out_wr = wr && (bus_addr == 5'd10 || bus_addr == 5'd11 || bus_addr == 5'd12);

    assert_oe_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 5'd0) |=> (pad_oe == $past(bus_wdata)));

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 5'd1) |=> (pad_out == ($past(pad_out) | $past(bus_wdata))));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 5'd2) |=> (pad_out == ($past(pad_out) & ~$past(bus_wdata))));

    assert_rvalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> bus_rvalid);

    assert_mask_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fast_out_wr |=> (((pad_out ^ $past(pad_out)) & $past(mask_q)) == '0));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

bind mgpio_port mgpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .mask_q     (mask_q)
);

// File: tb/mgpio_port_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for mgpio_port. The drive tasks push expected read
// data into a queue, and a monitor pops and compares each response.
module mgpio_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_dir = '0, m_out = '0, m_mask = '0, m_pin = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    mgpio_port u_mgpio_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] be);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = {8{be[k]}};
        return r;
    endfunction

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a)
            5'd0, 5'd8:                return m_dir;
            5'd1, 5'd2, 5'd11, 5'd12:  return m_out;
            5'd3:                      return m_pin;
            5'd9:                      return m_mask;
            5'd10:                     return m_pin & ~m_mask;
            default:                   return '0;
        endcase
    endfunction

    // one write cycle; the bench model follows the requirements
    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] ln, en;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        ln = lanes(be);
        en = ln & ~m_mask;
        case (a)
            5'd0:  m_dir = d;
            5'd1:  m_out = m_out | d;
            5'd2:  m_out = m_out & ~d;
            5'd8:  m_dir = (m_dir & ~ln) | (d & ln);
            5'd9:  m_mask = (m_mask & ~ln) | (d & ln);
            5'd10: m_out = (m_out & ~en) | (d & en);
            5'd11: m_out = m_out | (d & en);
            5'd12: m_out = m_out & ~(d & en);
            default: ;
        endcase
    endtask

    // one read cycle with an explicit expected value
    task automatic bus_rd_exp(input logic [4:0] a, input logic [31:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, input string req);
        bus_rd_exp(a, model_read(a), req);
    endtask

    // monitor: compares each read response with the scoreboard
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R5 unexpected response actual=%h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        bus_rd(5'd0, "R1 dir");
        bus_rd(5'd9, "R1 mask");
        bus_rd(5'd1, "R1 out");
        // R2: direction from both views
        bus_wr(5'd0, 32'hF0F0_1234, 4'h0);
        check("R2 legacy dir", pad_oe, 32'hF0F0_1234);
        bus_wr(5'd8, 32'hAABB_CCDD, 4'b0101);
        check("R2 fast dir", pad_oe, m_dir);
        bus_rd(5'd8, "R2 dir readback");
        // R3 / R4: legacy set and clear
        bus_wr(5'd1, 32'h0000_00FF, 4'h0);
        check("R3 set", pad_out, 32'h0000_00FF);
        bus_wr(5'd1, 32'h8000_0100, 4'h0);
        check("R3 set keeps zeros", pad_out, 32'h8000_01FF);
        bus_wr(5'd2, 32'h0000_000F, 4'h0);
        check("R4 clear", pad_out, 32'h8000_01F0);
        bus_rd(5'd2, "R5 latch via clear index");
        // R5 / R6: pin read through the synchronizer
        pad_in = 32'h1357_9BDF; m_pin = pad_in;
        repeat (3) @(negedge clk);
        bus_rd(5'd3, "R5 pin");
        pad_in = 32'hDEAD_BEEF;
        bus_rd_exp(5'd3, 32'h1357_9BDF, "R6 edge1 old");
        bus_rd_exp(5'd3, 32'h1357_9BDF, "R6 edge2 old");
        bus_rd_exp(5'd3, 32'hDEAD_BEEF, "R6 edge3 new");
        m_pin = pad_in;
        // R7: mask guards fast writes, not legacy ones
        bus_wr(5'd9, 32'h0000_FFFF, 4'hF);
        bus_rd(5'd9, "R7 mask readback");
        bus_wr(5'd11, 32'hFFFF_FFFF, 4'hF);
        check("R7 fast set masked", pad_out, m_out);
        check("R7 low half kept", pad_out[15:0], 16'h01F0);
        bus_wr(5'd12, 32'hFFFF_FFFF, 4'hF);
        check("R7 fast clear masked", pad_out, 32'h0000_01F0);
        bus_wr(5'd1, 32'h0000_0001, 4'h0);
        check("R7 legacy set ignores mask", pad_out, 32'h0000_01F1);
        // R8: full-port value write
        bus_wr(5'd10, 32'h1234_5678, 4'hF);
        check("R8 value masked", pad_out, 32'h1234_01F1);
        bus_wr(5'd9, 32'h0, 4'hF);
        bus_wr(5'd10, 32'hCAFE_F00D, 4'hF);
        check("R8 value full", pad_out, 32'hCAFE_F00D);
        // R9: byte lanes
        bus_wr(5'd10, 32'h1111_2222, 4'b0010);
        check("R9 lane 1 only", pad_out, 32'hCAFE_220D);
        bus_wr(5'd11, 32'hFFFF_FFFF, 4'b1000);
        check("R9 set lane 3", pad_out, 32'hFFFE_220D);
        bus_wr(5'd9, 32'hFF00_FF00, 4'b0011);
        bus_rd(5'd9, "R9 mask lanes");
        bus_wr(5'd0, 32'h0000_0001, 4'h0);
        check("R9 legacy ignores be", pad_oe, 32'h0000_0001);
        // R10: fast pin read masks bits
        bus_rd(5'd10, "R10 pin masked");
        // R11: unmapped
        bus_wr(5'd20, 32'hFFFF_FFFF, 4'hF);
        check("R11 unmapped write out", pad_out, m_out);
        check("R11 unmapped write oe", pad_oe, m_dir);
        bus_rd(5'd20, "R11 unmapped read");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R5 responses outstanding", exp_q.size(), 0);
        finish_run();
    end

endmodule